// File: doc/BRIEF.md
# Pipelined Load/Store Core with a Shared Single-Port Memory

This block is a compact 16-bit processor core. Each instruction is exactly one memory word, and the opcode and register fields sit at the same bit positions in every format. Arithmetic and logic work reads only registers or an immediate field. Memory is reached only through a load or a store.

Instructions and data live in one unified memory that has a single synchronous port. The core drives that port itself. It fetches one word per cycle, so a stream of ALU instructions retires one per clock through two stages: fetch, then execute. A load or store computes its effective address in its execute cycle and uses the port for its data access in that same cycle. Fetch therefore loses exactly one cycle for each memory instruction. Load data comes back in the following cycle and is written to the register file then, before the next instruction executes. A combinational debug port reads any register. A halt instruction parks the core so that a test harness can compare registers and memory against expected values.

Top module: `lsp_core`

## Requirements
- R1: While `rst` is high the port is idle (`mem_en`=0), all registers read 0 and `halted` is 0. In the first cycle after `rst` falls, the core fetches address 0 (`mem_en`=1, `mem_we`=0).
- R2: Instruction word layout. Opcode is bits [15:12], rd is [11:8], ra is [7:4], rb is [3:0]. The 8-bit immediate is [7:0], sign-extended. The memory offset is [3:0], sign-extended. Opcodes: 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 ADDI, 7 LDI, 8 LD, 9 ST, 10 JMP, 15 HALT.
- R3: ADD, SUB, AND, OR and XOR write rd = ra op rb, with 16-bit wraparound.
- R4: ADDI writes rd = rd + sext(imm8). LDI writes rd = sext(imm8).
- R5: Register 0 always reads as zero, and writes to it are discarded.
- R6: ALU instructions issue one per cycle with no stall, and each result is seen by the very next instruction.
- R7: LD writes rd with the word at (ra + sext(offset)) mod 2^ADDR_W. An offset of 0 gives register-indirect addressing. The loaded value is usable by the next instruction.
- R8: ST writes the value of register rd to the word at (ra + sext(offset)) mod 2^ADDR_W.
- R9: A load or store holds the port during its execute cycle and costs exactly one fetch cycle. A program of k executed words, m of them loads or stores, then HALT, raises `halted` on the (k+m+2)-th clock edge after reset release.
- R10: NOP and the unused opcodes 11 to 14 write no register and no memory word.
- R11: JMP fetches next from address imm8 (zero-extended). The word after the JMP is not executed, and the jump adds no cycle.
- R12: After HALT executes, `halted` stays 1, the port stays idle and the registers do not change.
- R13: `dbg_data` shows the current value of register `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory port access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| dbg_sel | input | 4 | Register index for the debug view |
| dbg_data | output | 16 | Value of the selected register |
| halted | output | 1 | Core has executed HALT |

## Verification
A wrong pipeline-valid bit or a misplaced stall cannot hide: it moves the edge on which `halted` rises. Every directed program checks that cycle exactly, so a single extra or missing bubble shows up at the end of the program. Wrong operand selection, wrong offset extension or wrong write-back steering corrupts a register or a memory word. That damage can be read through the debug port, or found in the memory model, as soon as the program halts a few cycles later. A load returning to the wrong register, or an ALU write colliding with a load return, is caught at the clock edge where it happens.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int WORD_W = 16;
    localparam int REG_N  = 16;
    localparam int REG_AW = $clog2(REG_N);
    localparam int RD_PORTS = 4;

    // opcode values; bit positions are fixed for all formats
    localparam logic [3:0] OPC_NOP  = 4'h0;
    localparam logic [3:0] OPC_ADD  = 4'h1;
    localparam logic [3:0] OPC_SUB  = 4'h2;
    localparam logic [3:0] OPC_AND  = 4'h3;
    localparam logic [3:0] OPC_OR   = 4'h4;
    localparam logic [3:0] OPC_XOR  = 4'h5;
    localparam logic [3:0] OPC_ADDI = 4'h6;
    localparam logic [3:0] OPC_LDI  = 4'h7;
    localparam logic [3:0] OPC_LD   = 4'h8;
    localparam logic [3:0] OPC_ST   = 4'h9;
    localparam logic [3:0] OPC_JMP  = 4'hA;
    localparam logic [3:0] OPC_HALT = 4'hF;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_PASSB
    } alu_op_e;

    typedef struct packed {
        alu_op_e             alu_op;
        logic                a_from_rd;
        logic                b_from_imm;
        logic                wr_reg;
        logic                is_ld;
        logic                is_st;
        logic                is_jmp;
        logic                is_halt;
        logic [REG_AW-1:0]   rd;
        logic [REG_AW-1:0]   ra;
        logic [REG_AW-1:0]   rb;
        logic [WORD_W-1:0]   imm;
        logic [WORD_W-1:0]   off;
        logic [7:0]          tgt;
    } dec_t;

    function automatic logic [WORD_W-1:0] sext8(input logic [7:0] v);
        return {{(WORD_W-8){v[7]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] sext4(input logic [3:0] v);
        return {{(WORD_W-4){v[3]}}, v};
    endfunction

endpackage

// File: rtl/lsp_regfile.sv
module lsp_regfile #(
    parameter int N_REGS = 16,
    parameter int W      = 16,
    parameter int N_RD   = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [$clog2(N_REGS)-1:0]      waddr_i,
    input  logic [W-1:0]                   wdata_i,
    input  logic [N_RD-1:0][$clog2(N_REGS)-1:0] raddr_i,
    output logic [N_RD-1:0][W-1:0]         rdata_o
);
    localparam int AW = $clog2(N_REGS);

    logic [W-1:0] regs_q [N_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
        end else if (we_i && (waddr_i != AW'(0))) begin
            regs_q[waddr_i] <= wdata_i;
        end
    end

    // one combinational read port per consumer
    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rdata_o[g] = (raddr_i[g] == AW'(0)) ? '0 : regs_q[raddr_i[g]];
    end
endmodule

// File: rtl/lsp_decode.sv
module lsp_decode
    import lsp_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o
);
    always_comb begin
        dec_o        = '0;
        dec_o.alu_op = ALU_ADD;
        dec_o.rd     = word_i[11:8];
        dec_o.ra     = word_i[7:4];
        dec_o.rb     = word_i[3:0];
        dec_o.imm    = sext8(word_i[7:0]);
        dec_o.off    = sext4(word_i[3:0]);
        dec_o.tgt    = word_i[7:0];
        case (word_i[15:12])
            OPC_ADD:  begin dec_o.wr_reg = 1'b1; dec_o.alu_op = ALU_ADD; end
            OPC_SUB:  begin dec_o.wr_reg = 1'b1; dec_o.alu_op = ALU_SUB; end
            OPC_AND:  begin dec_o.wr_reg = 1'b1; dec_o.alu_op = ALU_AND; end
            OPC_OR:   begin dec_o.wr_reg = 1'b1; dec_o.alu_op = ALU_OR;  end
            OPC_XOR:  begin dec_o.wr_reg = 1'b1; dec_o.alu_op = ALU_XOR; end
            OPC_ADDI: begin
                dec_o.wr_reg     = 1'b1;
                dec_o.a_from_rd  = 1'b1;
                dec_o.b_from_imm = 1'b1;
            end
            OPC_LDI:  begin
                dec_o.wr_reg     = 1'b1;
                dec_o.b_from_imm = 1'b1;
                dec_o.alu_op     = ALU_PASSB;
            end
            OPC_LD:   dec_o.is_ld   = 1'b1;
            OPC_ST:   dec_o.is_st   = 1'b1;
            OPC_JMP:  dec_o.is_jmp  = 1'b1;
            OPC_HALT: dec_o.is_halt = 1'b1;
            default:  ;  // NOP and unused codes do nothing
        endcase
    end
endmodule

// File: rtl/lsp_alu.sv
module lsp_alu
    import lsp_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] y_o
);
    always_comb begin
        case (op_i)
            ALU_ADD:   y_o = a_i + b_i;
            ALU_SUB:   y_o = a_i - b_i;
            ALU_AND:   y_o = a_i & b_i;
            ALU_OR:    y_o = a_i | b_i;
            ALU_XOR:   y_o = a_i ^ b_i;
            ALU_PASSB: y_o = b_i;
            default:   y_o = '0;
        endcase
    end
endmodule

// File: rtl/lsp_core.sv
module lsp_core
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [WORD_W-1:0] dbg_data,
    output logic              halted
);
    // pipeline state
    logic [ADDR_W-1:0] pc_q;
    logic              ir_valid_q;   // mem_rdata holds an instruction
    logic              ld_pend_q;    // mem_rdata holds load data
    logic [REG_AW-1:0] ld_rd_q;
    logic              halted_q;

    dec_t dec;
    lsp_decode u_dec (.word_i(mem_rdata), .dec_o(dec));

    logic [RD_PORTS-1:0][REG_AW-1:0] rf_raddr;
    logic [RD_PORTS-1:0][WORD_W-1:0] rf_rdata;
    logic              rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [WORD_W-1:0] rf_wdata;

    assign rf_raddr[0] = dec.ra;
    assign rf_raddr[1] = dec.rb;
    assign rf_raddr[2] = dec.rd;
    assign rf_raddr[3] = dbg_sel;

    lsp_regfile #(.N_REGS(REG_N), .W(WORD_W), .N_RD(RD_PORTS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .raddr_i (rf_raddr),
        .rdata_o (rf_rdata)
    );

    logic [WORD_W-1:0] ra_val, rb_val, rd_val;
    assign ra_val   = rf_rdata[0];
    assign rb_val   = rf_rdata[1];
    assign rd_val   = rf_rdata[2];
    assign dbg_data = rf_rdata[3];

    logic [WORD_W-1:0] op_a, op_b, alu_y;
    assign op_a = dec.a_from_rd  ? rd_val  : ra_val;
    assign op_b = dec.b_from_imm ? dec.imm : rb_val;

    lsp_alu u_alu (.op_i(dec.alu_op), .a_i(op_a), .b_i(op_b), .y_o(alu_y));

    // execute-stage classification
    logic exec_mem, exec_jmp, exec_halt, alu_wr;
    assign exec_mem  = ir_valid_q && (dec.is_ld || dec.is_st);
    assign exec_jmp  = ir_valid_q && dec.is_jmp;
    assign exec_halt = ir_valid_q && dec.is_halt;
    assign alu_wr    = ir_valid_q && dec.wr_reg;

    logic [ADDR_W-1:0] eff_addr;
    assign eff_addr = ra_val[ADDR_W-1:0] + dec.off[ADDR_W-1:0];

    // single port arbitration: data access wins over fetch
    logic fetch_go;
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = rd_val;
        fetch_go  = 1'b0;
        if (rst) begin
            mem_en = 1'b0;
        end else if (exec_mem) begin
            mem_en   = 1'b1;
            mem_we   = dec.is_st;
            mem_addr = eff_addr;
        end else if (exec_jmp) begin
            mem_en   = 1'b1;
            mem_addr = ADDR_W'(dec.tgt);
            fetch_go = 1'b1;
        end else if (!halted_q && !exec_halt) begin
            mem_en   = 1'b1;
            fetch_go = 1'b1;
        end
    end

    // one write port: ALU result or returning load data (never both)
    assign rf_we    = alu_wr || ld_pend_q;
    assign rf_waddr = ld_pend_q ? ld_rd_q   : dec.rd;
    assign rf_wdata = ld_pend_q ? mem_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= '0;
            ir_valid_q <= 1'b0;
            ld_pend_q  <= 1'b0;
            ld_rd_q    <= '0;
            halted_q   <= 1'b0;
        end else begin
            ir_valid_q <= fetch_go;
            if (fetch_go) pc_q <= mem_addr + ADDR_W'(1);
            ld_pend_q  <= exec_mem && dec.is_ld;
            ld_rd_q    <= dec.rd;
            if (exec_halt) halted_q <= 1'b1;
        end
    end

    assign halted = halted_q;
endmodule

// File: rtl/lsp_core_chk.sv
module lsp_core_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_en,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic              ir_valid,
    input logic              ld_pend,
    input logic              exec_mem,
    input logic              alu_wr,
    input logic [3:0]        dbg_sel,
    input logic [15:0]       dbg_data
);
    AST_HALT_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_en);                                  // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);                                   // R12
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc));                              // R12
    AST_SINGLE_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        !(alu_wr && ld_pend));                                // R9
    AST_DATA_STALLS_FETCH: assert property (@(posedge clk) disable iff (rst)
        exec_mem |=> !ir_valid);                              // R9
    AST_LOAD_SLOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ld_pend |-> !ir_valid);                               // R7
    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == 4'd0) |-> (dbg_data == 16'd0));           // R5
endmodule

bind lsp_core lsp_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_en   (mem_en),
    .halted   (halted),
    .pc       (pc_q),
    .ir_valid (ir_valid_q),
    .ld_pend  (ld_pend_q),
    .exec_mem (exec_mem),
    .alu_wr   (alu_wr),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
);

// File: tb/lsp_core_bench.sv
module lsp_core_bench;
    // opcodes as given in R2
    localparam logic [3:0] K_NOP = 4'h0, K_ADD = 4'h1, K_SUB = 4'h2, K_AND = 4'h3,
                           K_OR = 4'h4, K_XOR = 4'h5, K_ADDI = 4'h6, K_LDI = 4'h7,
                           K_LD = 4'h8, K_ST = 4'h9, K_JMP = 4'hA, K_HALT = 4'hF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en, mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [3:0]  dbg_sel = 4'd0;
    logic [15:0] dbg_data;
    logic        halted;

    always #10 clk = ~clk;  // 50 MHz

    lsp_core u_lsp_core (
        .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted)
    );

    logic [15:0] mem  [256];
    logic [15:0] snap [256];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    int n_chk  = 0;
    int n_fail = 0;

    function automatic logic [15:0] er(input logic [3:0] op, input logic [3:0] rd,
                                       input logic [3:0] ra, input logic [3:0] rb);
        return {op, rd, ra, rb};
    endfunction

    function automatic logic [15:0] ei(input logic [3:0] op, input logic [3:0] rd,
                                       input logic [7:0] imm);
        return {op, rd, imm};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_chk(input string req, input int r, input logic [15:0] exp);
        @(negedge clk);
        dbg_sel = 4'(r);
        #1;
        chk(req, dbg_data, exp);
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // release reset, run until halted, return edges since release
    task automatic run(output int edges);
        int w;
        @(negedge clk);
        rst = 1'b0;
        w = 0;
        while (!halted && w < 600) begin
            @(negedge clk);
            w++;
        end
        if (!halted) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 program never halted actual=0 expected=1");
        end
        edges = cyc;
    endtask

    task automatic t_alu();
        int e;
        enter_reset();
        mem[0] = ei(K_LDI, 1, 8'd5);
        mem[1] = ei(K_LDI, 2, 8'hFD);
        mem[2] = er(K_ADD, 3, 1, 2);
        mem[3] = er(K_SUB, 4, 1, 2);
        mem[4] = er(K_AND, 5, 1, 2);
        mem[5] = er(K_OR,  6, 1, 2);
        mem[6] = er(K_XOR, 7, 1, 2);
        mem[7] = ei(K_ADDI, 1, 8'd100);
        mem[8] = ei(K_ADDI, 2, 8'h80);
        mem[9] = ei(K_HALT, 0, 8'h00);
        run(e);
        chk("R6 back-to-back ALU timing (edges)", 16'(e), 16'd11);
        reg_chk("R3 ADD", 3, 16'h0002);
        reg_chk("R3 SUB", 4, 16'h0008);
        reg_chk("R3 AND", 5, 16'h0005);
        reg_chk("R3 OR",  6, 16'hFFFD);
        reg_chk("R3 XOR", 7, 16'hFFF8);
        reg_chk("R4 ADDI positive", 1, 16'h0069);
        reg_chk("R4 ADDI negative", 2, 16'hFF7D);
    endtask

    task automatic t_reset();
        int e;
        enter_reset();
        #1;
        chk("R1 port idle in reset", {15'd0, mem_en}, 16'd0);
        chk("R1 halted cleared", {15'd0, halted}, 16'd0);
        for (int r = 1; r < 16; r++) begin
            dbg_sel = 4'(r);
            #1;
            chk("R1 R13 register cleared", dbg_data, 16'h0000);
        end
        mem[0] = ei(K_HALT, 0, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 first fetch enable", {14'd0, mem_en, mem_we}, 16'd2);
        chk("R1 first fetch address", {8'd0, mem_addr}, 16'h0000);
        e = 0;
        while (!halted && e < 50) begin
            @(negedge clk);
            e++;
        end
        chk("R9 lone HALT timing (edges)", 16'(cyc), 16'd2);
    endtask

    task automatic t_zero_nop();
        int e;
        bit same;
        enter_reset();
        mem[0]  = ei(K_LDI, 9, 8'h11);
        mem[1]  = ei(K_LDI, 8, 8'h22);
        mem[2]  = ei(K_LDI, 0, 8'h07);
        mem[3]  = er(K_ADD, 8, 0, 0);
        mem[4]  = ei(K_ADDI, 0, 8'h03);
        mem[5]  = er(K_ADD, 10, 9, 0);
        mem[6]  = 16'h0955;               // NOP with rd=9
        mem[7]  = 16'hB9FF;               // unused opcodes, rd=9
        mem[8]  = 16'hC911;
        mem[9]  = 16'hD9AA;
        mem[10] = 16'hE977;
        mem[11] = ei(K_HALT, 0, 8'h00);
        mem[200] = 16'h5A5A;
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        run(e);
        chk("R9 timing with NOPs (edges)", 16'(e), 16'd13);
        reg_chk("R5 r0 reads zero", 0, 16'h0000);
        reg_chk("R5 r0 as operand", 8, 16'h0000);
        reg_chk("R5 add zero", 10, 16'h0011);
        reg_chk("R10 NOP/unused leave rd", 9, 16'h0011);
        same = 1'b1;
        for (int i = 0; i < 256; i++) if (mem[i] !== snap[i]) same = 1'b0;
        chk("R10 memory untouched", {15'd0, same}, 16'd1);
    endtask

    task automatic t_mem();
        int e;
        enter_reset();
        mem[0] = ei(K_LDI, 6, 8'hFE);
        mem[1] = er(K_LD, 7, 6, 4'd3);     // (-2 + 3) mod 256 = 1
        mem[2] = ei(K_LDI, 1, 8'h40);
        mem[3] = er(K_LD, 2, 1, 4'd0);     // register indirect
        mem[4] = er(K_LD, 3, 1, 4'd3);     // indexed
        mem[5] = er(K_ADD, 4, 2, 3);       // uses load result at once
        mem[6] = er(K_ST, 4, 1, 4'hF);     // offset -1
        mem[7] = er(K_ST, 3, 1, 4'd7);
        mem[8] = er(K_LD, 5, 1, 4'd7);
        mem[9] = ei(K_HALT, 0, 8'h00);
        mem[8'h40] = 16'h1234;
        mem[8'h43] = 16'hBEEF;
        run(e);
        chk("R9 one stall per load/store (edges)", 16'(e), 16'd17);
        reg_chk("R2 R7 negative base wraps", 7, er(K_LD, 7, 6, 4'd3));
        reg_chk("R7 indirect load", 2, 16'h1234);
        reg_chk("R7 indexed load", 3, 16'hBEEF);
        reg_chk("R7 load-use", 4, 16'hD123);
        chk("R2 R8 store negative offset", mem[8'h3F], 16'hD123);
        chk("R8 store positive offset", mem[8'h47], 16'hBEEF);
        reg_chk("R7 reload stored word", 5, 16'hBEEF);
    endtask

    task automatic t_jump_halt();
        int e;
        int busy;
        logic [15:0] r1_at_halt;
        enter_reset();
        mem[0] = ei(K_LDI, 1, 8'd1);
        mem[1] = ei(K_JMP, 0, 8'd5);
        mem[2] = ei(K_LDI, 1, 8'd9);
        mem[5] = ei(K_ADDI, 1, 8'd2);
        mem[6] = ei(K_HALT, 0, 8'h00);
        mem[7] = ei(K_LDI, 1, 8'd44);
        run(e);
        chk("R11 jump adds no cycle (edges)", 16'(e), 16'd5);
        reg_chk("R11 skipped word and target", 1, 16'h0003);
        r1_at_halt = dbg_data;
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (mem_en || !halted) busy++;
        end
        chk("R12 idle and halted after HALT", 16'(busy), 16'd0);
        reg_chk("R12 registers frozen", 1, r1_at_halt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_alu();
        t_reset();
        t_zero_nop();
        t_mem();
        t_jump_halt();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule